// File: doc/BRIEF.md
# Paged Serial EEPROM Target (two-wire bus)

This block is a two-wire serial bus target that fronts a byte-wide storage array, 1024 bytes by default. It watches SCL and SDA as open-drain lines, pulls SDA low through an output enable, detects START and STOP, answers its own device address and acknowledges bytes. A write sends a word address and then data bytes. The data bytes collect in a 16-byte page buffer whose offset wraps inside the selected page. A STOP then starts one timed internal write cycle that moves the buffered bytes into the array.

While that cycle runs the target releases SDA and does not answer its address. A controller can therefore poll for completion by repeating the address until it is acknowledged. Reads return bytes from the current address and advance it across the whole array. A random read is a write of the word address with no data bytes, followed by a repeated START and a read. A write-protect input is sampled once per write, at the SCL fall just before the first data bit. If it is high at that point, the first data byte is refused and the write is dropped.

The array holds the erased value 0xFF after reset. The length of the write cycle is a clock-count parameter.

Top module: `sereep_target`

## Requirements
- R1: A byte after START is an address when its bits [7:4] are 1010. Bit 3 is ignored, bits [2:1] select one of four 256-byte blocks and become word-address bits [9:8], and bit 0 is the direction (0 = write, 1 = read). On a match while idle, the target pulls SDA low in the ninth clock. On any other pattern it gives no acknowledge and ignores the bus until the next START.
- R2: In a write, every address, word-address and data byte is acknowledged (SDA low in the ninth clock). The target changes its SDA drive only while SCL is low, or on START or STOP.
- R3: Data bytes fill the page addressed by word-address bits [9:4], starting at the in-page offset given by bits [3:0]. The offset increments after each byte and wraps from 15 to 0 within the same page, so a later byte replaces an earlier byte at the same offset.
- R4: A STOP that follows at least one accepted data byte starts one internal write cycle of WR_CYCLES clocks. That cycle commits all buffered bytes of the page together and changes no other byte.
- R5: While the write cycle runs, SDA stays released, the address byte gets no acknowledge and the rest of that transaction is ignored. After the cycle ends, the address is acknowledged again.
- R6: The write-protect input is sampled at the SCL fall that ends the word-address acknowledge. If it is high there, the first data byte gets no acknowledge and nothing is written. A change of the input after that point has no effect on the write.
- R7: After reset, SDA is released and every byte of the array reads 0xFF.
- R8: A read returns the byte at the current address and increments the address after each byte, wrapping from the last byte of the array to byte 0. The current address comes from the block bits of the read address byte together with the last word address or read position.
- R9: When the controller answers a read byte with no acknowledge, the target stops driving SDA for the rest of the transaction.
- R10: A STOP with no accepted data byte, or a repeated START in the middle of a write, starts no write cycle and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the serial clock line |
| sda_i | input | 1 | Level of the serial data line |
| wp_i | input | 1 | Write protect, high blocks writes |
| sda_oe | output | 1 | When high, pulls the serial data line low |

## Verification
The bench sends 18 bytes into one page, starting two bytes before the page end. A design that did not wrap the offset would spill into the next page, and one that did not overwrite earlier bytes would keep stale data; both show up in the read-back of the page and of the byte after it.

It polls straight after a STOP and expects no acknowledge. It also sends a full write during the busy time, which a target that answers during its own cycle would store. Write protect is raised both before the sample point and after it, so a design that samples it at the wrong clock either accepts a protected write or refuses a legal one.

A read is run across the top of the array, and a read is continued after the controller's no-acknowledge. A repeated START is sent in the middle of a write, and a bare STOP is sent after the word address. A design that committed on those, or drove SDA after the no-acknowledge, returns wrong bytes or stays busy.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

    // Fixed upper nibble of the target's address byte
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,   // ignoring the bus until START
        M_DEV   = 3'd1,   // shifting in the address byte
        M_WADDR = 3'd2,   // shifting in the word address
        M_WDATA = 3'd3,   // shifting in data bytes
        M_READ  = 3'd4    // shifting out data bytes
    } mode_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic prefix_ok(input logic [7:0] b);
        return b[7:4] == DEV_PREFIX;
    endfunction

endpackage

// File: rtl/sereep_edges.sv
module sereep_edges
    import sereep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_lvl
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] scl_sh, sda_sh;
    logic scl_now, scl_old, sda_now, sda_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SH_W-2:0], scl_i};
            sda_sh <= {sda_sh[SH_W-2:0], sda_i};
        end
    end

    assign scl_now = scl_sh[SH_W-2];
    assign scl_old = scl_sh[SH_W-1];
    assign sda_now = sda_sh[SH_W-2];
    assign sda_old = sda_sh[SH_W-1];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
        ev.sda      = sda_now;
    end

    assign scl_lvl = scl_now;

endmodule

// File: rtl/sereep_core.sv
module sereep_core
    import sereep_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  bus_ev_t                  ev,
    input  logic                     busy,
    input  logic                     wp_i,
    input  logic [7:0]               rd_data,
    output logic                     sda_oe,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     buf_wr,
    output logic [PAGE_W-1:0]        buf_off,
    output logic [7:0]               buf_data,
    output logic                     buf_clr,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic                     wp_lat,
    output mode_e                    mode_o
);
    localparam int BLK_W = ADDR_W - 8;
    localparam logic [PAGE_W-1:0] OFF_ONE  = 1;
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    mode_e             mode;
    logic [3:0]        bitcnt;
    logic              in_ack;
    logic              have_data;
    logic [7:0]        rx, tx;
    logic [ADDR_W-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= M_IDLE;
            bitcnt    <= '0;
            in_ack    <= 1'b0;
            have_data <= 1'b0;
            rx        <= '0;
            tx        <= '0;
            cur       <= '0;
            sda_oe    <= 1'b0;
            wp_lat    <= 1'b0;
            buf_wr    <= 1'b0;
            buf_off   <= '0;
            buf_data  <= '0;
            buf_clr   <= 1'b0;
            commit    <= 1'b0;
        end else begin
            buf_wr  <= 1'b0;
            buf_clr <= 1'b0;
            commit  <= 1'b0;
            if (ev.start) begin
                mode      <= M_DEV;
                bitcnt    <= '0;
                in_ack    <= 1'b0;
                have_data <= 1'b0;
                sda_oe    <= 1'b0;
                buf_clr   <= 1'b1;
            end else if (ev.stop) begin
                if (mode == M_WDATA && have_data) commit <= 1'b1;
                mode   <= M_IDLE;
                bitcnt <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (mode != M_IDLE) begin
                if (ev.scl_rise) begin
                    if (in_ack) begin
                        // controller's answer to a read byte
                        if (mode == M_READ && ev.sda) mode <= M_IDLE;
                    end else begin
                        rx     <= {rx[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end
                end else if (ev.scl_fall) begin
                    if (in_ack) begin
                        // end of the acknowledge clock
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        if (mode == M_READ) begin
                            sda_oe <= ~rd_data[7];
                            tx     <= {rd_data[6:0], 1'b0};
                            cur    <= cur + ADDR_ONE;
                        end
                        if (mode == M_WDATA && !have_data) wp_lat <= wp_i;
                    end else if (bitcnt == 4'd8) begin
                        in_ack <= 1'b1;
                        case (mode)
                            M_DEV: begin
                                if (prefix_ok(rx) && !busy) begin
                                    sda_oe              <= 1'b1;
                                    cur[ADDR_W-1:8]     <= rx[BLK_W:1];
                                    mode                <= rx[0] ? M_READ : M_WADDR;
                                end else begin
                                    mode <= M_IDLE;
                                end
                            end
                            M_WADDR: begin
                                sda_oe    <= 1'b1;
                                cur[7:0]  <= rx;
                                mode      <= M_WDATA;
                            end
                            M_WDATA: begin
                                if (wp_lat) begin
                                    mode <= M_IDLE;
                                end else begin
                                    sda_oe             <= 1'b1;
                                    buf_wr             <= 1'b1;
                                    buf_data           <= rx;
                                    buf_off            <= cur[PAGE_W-1:0];
                                    cur[PAGE_W-1:0]    <= cur[PAGE_W-1:0] + OFF_ONE;
                                    have_data          <= 1'b1;
                                end
                            end
                            M_READ:  sda_oe <= 1'b0;
                            default: mode <= M_IDLE;
                        endcase
                    end else if (mode == M_READ) begin
                        sda_oe <= ~tx[7];
                        tx     <= {tx[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rd_addr   = cur;
    assign page_base = cur[ADDR_W-1:PAGE_W];
    assign mode_o    = mode;

endmodule

// File: rtl/sereep_store.sv
module sereep_store #(
    parameter int DEPTH     = 1024,
    parameter int PAGE      = 16,
    parameter int WR_CYCLES = 400
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               buf_wr,
    input  logic [$clog2(PAGE)-1:0]            buf_off,
    input  logic [7:0]                         buf_data,
    input  logic                               buf_clr,
    input  logic                               commit,
    input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_base,
    input  logic [$clog2(DEPTH)-1:0]           rd_addr,
    output logic [7:0]                         rd_data,
    output logic                               busy,
    output logic                               mem_we
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PAGE_W = $clog2(PAGE);
    localparam int PB_W   = ADDR_W - PAGE_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);
    localparam logic [PAGE_W-1:0] LAST_OFF = PAGE_W'(PAGE - 1);
    localparam logic [CNT_W-1:0]  CYC_LOAD = CNT_W'(WR_CYCLES);

    logic [7:0]        mem  [DEPTH];
    logic [7:0]        pbuf [PAGE];
    logic [PAGE-1:0]   pvalid;
    logic [PB_W-1:0]   base;
    logic [CNT_W-1:0]  busy_cnt;
    logic [PAGE_W-1:0] cidx;
    logic              committing;

    assign busy    = busy_cnt != '0;
    assign mem_we  = committing & pvalid[cidx];
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            for (int j = 0; j < PAGE; j++) pbuf[j] <= 8'hFF;
            pvalid     <= '0;
            base       <= '0;
            busy_cnt   <= '0;
            cidx       <= '0;
            committing <= 1'b0;
        end else begin
            if (commit) begin
                base       <= page_base;
                busy_cnt   <= CYC_LOAD;
                cidx       <= '0;
                committing <= 1'b1;
            end else if (busy) begin
                busy_cnt <= busy_cnt - 1'b1;
            end

            if (committing) begin
                // one buffered slot per clock, early in the write cycle
                if (pvalid[cidx]) mem[{base, cidx}] <= pbuf[cidx];
                if (cidx == LAST_OFF) begin
                    committing <= 1'b0;
                    pvalid     <= '0;
                end else begin
                    cidx <= cidx + 1'b1;
                end
            end else if (buf_clr && !busy) begin
                pvalid <= '0;
            end else if (buf_wr) begin
                pbuf[buf_off]   <= buf_data;
                pvalid[buf_off] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sereep_target.sv
module sereep_target
    import sereep_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int PB_W   = ADDR_W - PAGE_W;

    bus_ev_t           ev;
    logic              scl_lvl;
    logic              busy, mem_we, wp_lat;
    logic              buf_wr, buf_clr, commit;
    logic [PAGE_W-1:0] buf_off;
    logic [7:0]        buf_data, rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [PB_W-1:0]   page_base;
    mode_e             mode;

    sereep_edges #(.SYNC_STAGES(2)) u_edges (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev      (ev),
        .scl_lvl (scl_lvl)
    );

    sereep_core #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .wp_i      (wp_i),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .rd_addr   (rd_addr),
        .buf_wr    (buf_wr),
        .buf_off   (buf_off),
        .buf_data  (buf_data),
        .buf_clr   (buf_clr),
        .commit    (commit),
        .page_base (page_base),
        .wp_lat    (wp_lat),
        .mode_o    (mode)
    );

    sereep_store #(
        .DEPTH     (MEM_BYTES),
        .PAGE      (PAGE_BYTES),
        .WR_CYCLES (WR_CYCLES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .buf_wr    (buf_wr),
        .buf_off   (buf_off),
        .buf_data  (buf_data),
        .buf_clr   (buf_clr),
        .commit    (commit),
        .page_base (page_base),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .mem_we    (mem_we)
    );

endmodule

// File: rtl/sereep_chk.sv
module sereep_chk
    import sereep_pkg::*;
#(
    parameter int PB_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            sda_oe,
    input logic            scl_lvl,
    input logic            ev_start,
    input logic            ev_stop,
    input logic            busy,
    input logic            mem_we,
    input logic            wp_lat,
    input mode_e           mode,
    input logic [PB_W-1:0] page_base
);

    assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(ev_start) || $past(ev_stop)));

    assert_page_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == M_WDATA && $past(mode) == M_WDATA) |-> $stable(page_base));

    assert_cycle_after_stop_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ev_stop, 2));

    assert_write_in_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    assert_quiet_busy_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wp_lat));

endmodule

bind sereep_target sereep_chk #(.PB_W(PB_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .scl_lvl   (scl_lvl),
    .ev_start  (ev.start),
    .ev_stop   (ev.stop),
    .busy      (busy),
    .mem_we    (mem_we),
    .wp_lat    (wp_lat),
    .mode      (mode),
    .page_base (page_base)
);

// File: tb/sim_sereep_target.sv
module sim_sereep_target;

    localparam int Q      = 8;      // clocks per quarter bit
    localparam int WRCYC  = 400;
    localparam int DEPTH  = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [DEPTH];

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    sereep_target #(.MEM_BYTES(DEPTH), .PAGE_BYTES(16), .WR_CYCLES(WRCYC)) u0 (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] blk, input logic rw);
        return {4'b1010, 1'b0, blk, rw};
    endfunction

    function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
        return 8'(seed + k * 37);
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2 * Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        acked = ~sda_line;
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            m_scl = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            m_scl = 1'b0;
        end
        wq(Q);
        m_sda = nack; wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    // Poll with address-only writes until acknowledged; returns tries
    task automatic wait_ready(output int tries);
        logic a;
        tries = 0;
        a = 1'b0;
        while (!a && tries < 40) begin
            bus_start();
            send_byte(dev(2'd0, 1'b0), a);
            bus_stop();
            tries++;
        end
        check(a, "R5", "address acknowledged after cycle", a, 1);
    endtask

    task automatic do_write(input logic [9:0] addr, input int n, input logic [7:0] seed);
        logic a;
        int t;
        bus_start();
        send_byte(dev(addr[9:8], 1'b0), a);
        check(a, "R2", "write address ack", a, 1);
        send_byte(addr[7:0], a);
        check(a, "R2", "word address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(pat(seed, k), a);
            check(a, "R2", "data byte ack", a, 1);
            ref_mem[{addr[9:4], 4'(addr[3:0] + k)}] = pat(seed, k);
        end
        bus_stop();
        wait_ready(t);
    endtask

    task automatic rand_read(input logic [9:0] addr, input int n, input string req);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(dev(addr[9:8], 1'b0), a);
        check(a, req, "dummy write address ack", a, 1);
        send_byte(addr[7:0], a);
        check(a, req, "dummy word address ack", a, 1);
        bus_start();
        send_byte(dev(addr[9:8], 1'b1), a);
        check(a, req, "read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            logic [9:0] p;
            p = addr + 10'(k);
            recv_byte(k == n - 1, d);
            check(d == ref_mem[p], req, $sformatf("read byte at %0h", p), d, ref_mem[p]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R7", "SDA released after reset", sda_oe, 0);
        rand_read(10'h2A0, 3, "R7");
    endtask

    task automatic t_address();
        logic a;
        bus_start();
        send_byte(8'b1011_0000, a);
        check(!a, "R1", "wrong prefix not acknowledged", a, 0);
        send_byte(8'h00, a);
        check(!a, "R1", "rest of foreign transaction ignored", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'b1010_1000, a);
        check(a, "R1", "bit 3 ignored in address", a, 1);
        bus_stop();
    endtask

    task automatic t_byte_poll();
        logic a;
        int t;
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        check(a, "R2", "address ack", a, 1);
        send_byte(8'h05, a);
        check(a, "R2", "word address ack", a, 1);
        send_byte(8'hA5, a);
        check(a, "R2", "data ack", a, 1);
        bus_stop();
        ref_mem[10'h005] = 8'hA5;
        // during the cycle: full write must be ignored
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        check(!a, "R5", "no ack while busy", a, 0);
        send_byte(8'h20, a);
        check(!a, "R5", "word address ignored while busy", a, 0);
        send_byte(8'h99, a);
        check(!a, "R5", "data ignored while busy", a, 0);
        bus_stop();
        wait_ready(t);
        rand_read(10'h005, 1, "R4");
        rand_read(10'h020, 1, "R5");
    endtask

    task automatic t_page_wrap();
        do_write(10'h10E, 18, 8'h31);
        rand_read(10'h0FF, 19, "R3");
    endtask

    task automatic t_protect();
        logic a;
        int t;
        wp = 1'b1;
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        check(a, "R6", "address ack with wp high", a, 1);
        send_byte(8'h40, a);
        check(a, "R6", "word address ack with wp high", a, 1);
        send_byte(8'h12, a);
        check(!a, "R6", "protected data byte refused", a, 0);
        bus_stop();
        wp = 1'b0;
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        check(a, "R6", "no write cycle after refusal", a, 1);
        bus_stop();
        rand_read(10'h040, 1, "R6");
        // raised only after the sample point: write proceeds
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        send_byte(8'h50, a);
        send_byte(8'h61, a);
        check(a, "R6", "first byte accepted with wp low at sample", a, 1);
        wp = 1'b1;
        send_byte(8'h62, a);
        check(a, "R6", "late wp has no effect", a, 1);
        bus_stop();
        wp = 1'b0;
        ref_mem[10'h050] = 8'h61;
        ref_mem[10'h051] = 8'h62;
        wait_ready(t);
        check(t > 1, "R4", "write cycle observed after late wp", t, 2);
        rand_read(10'h050, 2, "R6");
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        send_byte(8'h80, a);
        send_byte(8'h77, a);
        check(a, "R10", "data ack before repeated start", a, 1);
        bus_start();
        send_byte(dev(2'd0, 1'b1), a);
        check(a, "R10", "no cycle after repeated start", a, 1);
        recv_byte(1'b1, d);
        check(d == 8'hFF, "R10", "read continues at next address", d, 8'hFF);
        bus_stop();
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        send_byte(8'h90, a);
        bus_stop();
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        check(a, "R10", "no cycle after bare stop", a, 1);
        bus_stop();
        rand_read(10'h080, 1, "R10");
    endtask

    task automatic t_seq_nack();
        logic a;
        logic [7:0] d;
        do_write(10'h3FF, 1, 8'h5C);
        rand_read(10'h3FE, 4, "R8");
        bus_start();
        send_byte(dev(2'd0, 1'b0), a);
        send_byte(8'h05, a);
        bus_start();
        send_byte(dev(2'd0, 1'b1), a);
        recv_byte(1'b1, d);
        check(d == 8'hA5, "R9", "byte before controller nack", d, 8'hA5);
        recv_byte(1'b1, d);
        check(d == 8'hFF, "R9", "line released after nack", d, 8'hFF);
        check(sda_oe == 1'b0, "R9", "no drive after nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        wq(5);
        rst = 1'b0;
        wq(5);
        t_reset();
        t_address();
        t_byte_poll();
        t_page_wrap();
        t_protect();
        t_abort();
        t_seq_nack();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule